// File: doc/BRIEF.md
# Opcode-Addressed Serial Register Access Slave

This block is the serial front end of a peripheral. An external controller pulls chip select low, clocks in an 8-bit instruction, and then exchanges a data field whose length depends on the target that the instruction names. The instruction holds a direction bit, a 5-bit target selector and two bits that are ignored. Write data arrives on the serial input most significant bit first. Read data leaves on the serial output, starting on the falling serial clock edge that follows the last instruction bit, with no dummy cycles between the two phases.

Inside the chip the slave drives a simple register-file port. It carries the selector, a byte index, a one-hot target kind, write data with a write strobe, and a read strobe whose data comes back one system clock later. Control registers move 8 bits, label words move 32 bits, and each of the two label-match enable memories moves 256 bits as 32 bytes in sequence, each byte with its own strobe. The serial pins are oversampled by the system clock, so the serial clock must stay slow compared with the system clock.

Top module: `spi_opcode_slave`

## Requirements
- R1: After chip select falls, the instruction is taken from `spi_si` on 8 rising `spi_sck` edges, first bit = instruction bit 7. Bit 7 = 1 selects a read and 0 selects a write. Bits 6..2 form the selector, and bits 1..0 have no effect.
- R2: Selector 0..7 is a control register with an 8-bit data field. Selector 8..11 is a label word with a 32-bit field. Selector 12..13 is a label-match memory with a 256-bit field. `rf_kind` is 3'b001, 3'b010 or 3'b100 for these kinds from the end of the instruction until chip select rises, and it is 0 at all other times.
- R3: A control or label write produces exactly one `rf_wr` pulse after the last data bit. `rf_wdata` holds the field right-aligned, first serial bit as MSB, with `rf_byte` = 0.
- R4: A match-memory write produces 32 `rf_wr` pulses with `rf_byte` running 0..31 in order. Each pulse carries one byte in `rf_wdata[7:0]`, and the first byte on the wire is byte 0.
- R5: A read pulses `rf_rd` with `rf_byte` = 0 when the instruction completes. `spi_so` shows the field MSB from the falling edge right after the last instruction bit. Control reads return `rf_rdata[7:0]` and label reads return `rf_rdata[31:0]`.
- R6: A match-memory read fetches bytes 1..31 with further `rf_rd` pulses and sends all 256 bits without gaps, byte 0 first and each byte MSB first.
- R7: `spi_so_oe` and `spi_so` are 0 while chip select is high and throughout the instruction phase.
- R8: Releasing chip select before the field is complete aborts the transfer. A control or label write is not committed, and the next transfer decodes a fresh instruction. A rising edge that arrives together with the chip-select release is not counted.
- R9: Selectors 14..31 use an 8-bit field. Writes to them produce no `rf_wr`. Reads of them produce no `rf_rd` and return all zeros.
- R10: Serial clocks after the field is complete, before chip select rises, produce no further strobes.
- R11: After reset, `spi_so`, `spi_so_oe`, `rf_wr`, `rf_rd` and `rf_kind` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for `spi_so` |
| rf_addr | output | SEL_W | Selector of the current access |
| rf_byte | output | IDX_W | Byte index within a match-memory access |
| rf_kind | output | 3 | One-hot target kind: control, label, match |
| rf_wdata | output | DATA_W | Write data |
| rf_wr | output | 1 | Write strobe, one cycle |
| rf_rd | output | 1 | Read strobe, one cycle |
| rf_rdata | input | DATA_W | Read data, valid the cycle after `rf_rd` |

## Verification
The conflict that matters is a rising serial clock edge that completes a write and a chip-select release that reach the synchronised domain in the same system cycle. The abort must win, so no write is committed. The bench provokes this by raising `spi_sck` and `spi_cs_n` at the same instant on the last data bit. It then reads the register back over the serial port and counts write strobes to confirm nothing was stored. The same write with chip select released half a serial period later must commit, which shows that only the exact coincidence is discarded.

// File: rtl/spi_opcode_pkg.sv
package spi_opcode_pkg;

  typedef enum logic [1:0] {
    TGT_CTRL  = 2'd0,
    TGT_LABEL = 2'd1,
    TGT_MATCH = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OP   = 3'd1,
    ST_WR   = 3'd2,
    ST_RD   = 3'd3,
    ST_DONE = 3'd4
  } st_e;

  function automatic logic [2:0] kind_bits(tgt_e t);
    case (t)
      TGT_CTRL:  kind_bits = 3'b001;
      TGT_LABEL: kind_bits = 3'b010;
      TGT_MATCH: kind_bits = 3'b100;
      default:   kind_bits = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic si_s
);
  localparam int NP = 3;
  localparam logic [NP-1:0] RST_VAL = 3'b010;  // si, cs_n, sck

  logic [NP-1:0] pin_i;
  logic [STAGES:0] chain_q [NP];

  assign pin_i = {si_i, cs_n_i, sck_i};

  for (genvar p = 0; p < NP; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[p] <= {(STAGES+1){RST_VAL[p]}};
      else        chain_q[p] <= {chain_q[p][STAGES-1:0], pin_i[p]};
    end
  end

  assign sck_rise = chain_q[0][STAGES-1] & ~chain_q[0][STAGES];
  assign sck_fall = ~chain_q[0][STAGES-1] & chain_q[0][STAGES];
  assign cs_act   = ~chain_q[1][STAGES-1];
  assign si_s     = chain_q[2][STAGES-1];

endmodule

// File: rtl/spi_target_decode.sv
module spi_target_decode
  import spi_opcode_pkg::*;
#(
  parameter int SEL_W      = 5,
  parameter int CNT_W      = 9,
  parameter int DATA_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int MATCH_LEN  = 256,
  parameter int CTRL_LAST  = 7,
  parameter int LABEL_LAST = 11,
  parameter int MATCH_LAST = 13
) (
  input  logic [SEL_W-1:0] sel,
  output tgt_e             tgt,
  output logic [CNT_W-1:0] len
);
  always_comb begin
    if (sel <= SEL_W'(CTRL_LAST)) begin
      tgt = TGT_CTRL;
      len = CNT_W'(BYTE_W);
    end else if (sel <= SEL_W'(LABEL_LAST)) begin
      tgt = TGT_LABEL;
      len = CNT_W'(DATA_W);
    end else if (sel <= SEL_W'(MATCH_LAST)) begin
      tgt = TGT_MATCH;
      len = CNT_W'(MATCH_LEN);
    end else begin
      tgt = TGT_NONE;
      len = CNT_W'(BYTE_W);
    end
  end
endmodule

// File: rtl/spi_opcode_slave.sv
module spi_opcode_slave
  import spi_opcode_pkg::*;
#(
  parameter int SEL_W       = 5,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_LAST   = 7,
  parameter int LABEL_LAST  = 11,
  parameter int MATCH_LAST  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic [SEL_W-1:0]  rf_addr,
  output logic [IDX_W-1:0]  rf_byte,
  output logic [2:0]        rf_kind,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_wr,
  output logic              rf_rd,
  input  logic [DATA_W-1:0] rf_rdata
);
  localparam int OP_W      = 8;
  localparam int BYTE_W    = 8;
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int CNT_W     = IDX_W + BIT_W + 1;
  localparam int MATCH_LEN = (1 << IDX_W) * BYTE_W;

  logic sck_rise, sck_fall, cs_act, si_s;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .si_i(spi_si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .si_s(si_s)
  );

  st_e               st_q, st_d;
  logic [OP_W-2:0]   op_q, op_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, len_q, len_d, nxt;
  tgt_e              tgt_q, tgt_d;
  logic [SEL_W-1:0]  addr_q, addr_d;
  logic [IDX_W-1:0]  byte_q, byte_d;
  logic [DATA_W-1:0] rx_q, rx_d, tx_q, tx_d, wdata_q, wdata_d;
  logic              so_q, so_d, oe_q, oe_d, wr_q, wr_d, rdstb_q, rdstb_d, ld_q, ld_d;

  logic [SEL_W-1:0]  dec_sel;
  tgt_e              dec_tgt;
  logic [CNT_W-1:0]  dec_len;

  // selector sits in instruction bits 6..2; op_q[k] holds instruction bit k+1
  assign dec_sel = op_q[OP_W-3 -: SEL_W];

  spi_target_decode #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .MATCH_LEN(MATCH_LEN),
    .CTRL_LAST(CTRL_LAST), .LABEL_LAST(LABEL_LAST), .MATCH_LAST(MATCH_LAST)
  ) i_dec (
    .sel(dec_sel), .tgt(dec_tgt), .len(dec_len)
  );

  always_comb begin
    st_d = st_q;   op_d = op_q;     cnt_d = cnt_q;  tgt_d = tgt_q;  len_d = len_q;
    addr_d = addr_q; byte_d = byte_q; rx_d = rx_q;  tx_d = tx_q;
    so_d = so_q;   oe_d = oe_q;     wr_d = 1'b0;    wdata_d = wdata_q;
    rdstb_d = 1'b0; ld_d = 1'b0;
    nxt = cnt_q + 1'b1;
    if (!cs_act) begin
      st_d = ST_IDLE; cnt_d = '0; so_d = 1'b0; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_OP: begin
          st_d = ST_OP;
          if (sck_rise) begin
            op_d  = {op_q[OP_W-3:0], si_s};
            cnt_d = nxt;
            if (cnt_q == CNT_W'(OP_W-1)) begin
              addr_d = dec_sel; tgt_d = dec_tgt; len_d = dec_len;
              cnt_d = '0; byte_d = '0; rx_d = '0; tx_d = '0;
              if (op_q[OP_W-2]) begin
                st_d    = ST_RD;
                rdstb_d = (dec_tgt != TGT_NONE);
              end else begin
                st_d = ST_WR;
              end
            end
          end
        end
        ST_WR: begin
          if (sck_rise) begin
            rx_d  = {rx_q[DATA_W-2:0], si_s};
            cnt_d = nxt;
            if (tgt_q == TGT_MATCH) begin
              if (nxt[BIT_W-1:0] == '0) begin
                wr_d    = 1'b1;
                wdata_d = {{(DATA_W-BYTE_W){1'b0}}, rx_q[BYTE_W-2:0], si_s};
                byte_d  = cnt_q[BIT_W +: IDX_W];
              end
            end else if (nxt == len_q && tgt_q != TGT_NONE) begin
              wr_d    = 1'b1;
              wdata_d = {rx_q[DATA_W-2:0], si_s};
              byte_d  = '0;
            end
            if (nxt == len_q) st_d = ST_DONE;
          end
        end
        ST_RD: begin
          ld_d = rdstb_q;
          if (sck_fall) begin
            so_d = tx_q[DATA_W-1];
            tx_d = {tx_q[DATA_W-2:0], 1'b0};
            oe_d = 1'b1;
            if (tgt_q == TGT_MATCH && cnt_q[BIT_W-1:0] == BIT_W'(BYTE_W-1)
                && cnt_q[BIT_W +: IDX_W] != '1) begin
              rdstb_d = 1'b1;
              byte_d  = cnt_q[BIT_W +: IDX_W] + 1'b1;
            end
          end
          if (sck_rise) begin
            cnt_d = nxt;
            if (nxt == len_q) st_d = ST_DONE;
          end
          if (ld_q) begin
            tx_d = (tgt_q == TGT_LABEL) ? rf_rdata
                                        : {rf_rdata[BYTE_W-1:0], {(DATA_W-BYTE_W){1'b0}}};
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; op_q <= '0; cnt_q <= '0; tgt_q <= TGT_NONE; len_q <= '0;
      addr_q <= '0; byte_q <= '0; rx_q <= '0; tx_q <= '0; wdata_q <= '0;
      so_q <= 1'b0; oe_q <= 1'b0; wr_q <= 1'b0; rdstb_q <= 1'b0; ld_q <= 1'b0;
    end else begin
      st_q <= st_d; op_q <= op_d; cnt_q <= cnt_d; tgt_q <= tgt_d; len_q <= len_d;
      addr_q <= addr_d; byte_q <= byte_d; rx_q <= rx_d; tx_q <= tx_d; wdata_q <= wdata_d;
      so_q <= so_d; oe_q <= oe_d; wr_q <= wr_d; rdstb_q <= rdstb_d; ld_q <= ld_d;
    end
  end

  assign spi_so    = so_q;
  assign spi_so_oe = oe_q;
  assign rf_addr   = addr_q;
  assign rf_byte   = byte_q;
  assign rf_wdata  = wdata_q;
  assign rf_wr     = wr_q;
  assign rf_rd     = rdstb_q;
  assign rf_kind   = (st_q == ST_WR || st_q == ST_RD || st_q == ST_DONE) ? kind_bits(tgt_q) : 3'b000;

  // R7
  so_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (!spi_so_oe && !spi_so));

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (rf_kind == 3'b000 && !rf_wr));

  // R2
  kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rf_kind));

  // R9
  rd_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |-> (rf_kind != 3'b000 && !rf_wr));

  // R3
  wr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> (rf_kind != 3'b000));

  // R7
  op_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OP) |-> !spi_so_oe);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && $past(st_q == ST_DONE)) |-> (!rf_wr && !rf_rd));

endmodule

// File: tb/test_spi_opcode_slave.sv
module test_spi_opcode_slave;
  localparam int HP = 6;

  logic clk, rst_n, spi_sck, spi_cs_n, spi_si;
  logic spi_so, spi_so_oe, rf_wr, rf_rd;
  logic [4:0]  rf_addr, rf_byte;
  logic [2:0]  rf_kind;
  logic [31:0] rf_wdata, rf_rdata;

  int errors = 0;
  int checks = 0;

  spi_opcode_slave i_spi_opcode_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
    .spi_so(spi_so), .spi_so_oe(spi_so_oe), .rf_addr(rf_addr), .rf_byte(rf_byte),
    .rf_kind(rf_kind), .rf_wdata(rf_wdata), .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_rdata(rf_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // register-file model
  logic [7:0]  ctrl_m [8];
  logic [31:0] lab_m  [4];
  logic [7:0]  mat_m  [2][32];
  int wr_cnt, rd_cnt, order_err;
  logic [5:0] mat_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) ctrl_m[i] <= 8'h10 + 8'(i);
      for (int i = 0; i < 4; i++) lab_m[i] <= 32'h0;
      for (int c = 0; c < 2; c++) for (int b = 0; b < 32; b++) mat_m[c][b] <= 8'h0;
      wr_cnt <= 0; rd_cnt <= 0; order_err <= 0; mat_next <= '0;
      rf_rdata <= '0;
    end else begin
      if (rf_kind != 3'b100) mat_next <= '0;
      if (rf_wr) begin
        wr_cnt <= wr_cnt + 1;
        if (rf_kind == 3'b001) ctrl_m[rf_addr[2:0]] <= rf_wdata[7:0];
        if (rf_kind == 3'b010) lab_m[rf_addr[1:0]] <= rf_wdata;
        if (rf_kind == 3'b100) begin
          mat_m[rf_addr[0]][rf_byte] <= rf_wdata[7:0];
          if ({1'b0, rf_byte} != mat_next) order_err <= order_err + 1;
          mat_next <= mat_next + 1'b1;
        end
      end
      if (rf_rd) begin
        rd_cnt <= rd_cnt + 1;
        case (rf_kind)
          3'b001:  rf_rdata <= {24'h0, ctrl_m[rf_addr[2:0]]};
          3'b010:  rf_rdata <= lab_m[rf_addr[1:0]];
          3'b100:  rf_rdata <= {24'h0, mat_m[rf_addr[0]][rf_byte]};
          default: rf_rdata <= 32'h0;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  bit oe_op_seen;
  logic [2:0] kind_seen;

  task automatic xfer(input logic [7:0] op, input int nbits, input logic [255:0] din,
                      output logic [255:0] dout, input int cut, input int extra, input bit race);
    dout = '0; oe_op_seen = 1'b0; kind_seen = '0;
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < 8 + nbits; i++) begin
      if (i == cut) break;
      spi_si = (i < 8) ? op[7-i] : din[nbits-1-(i-8)];
      repeat (HP) @(negedge clk);
      if (i < 8) begin
        if (spi_so_oe) oe_op_seen = 1'b1;
      end else begin
        dout[nbits-1-(i-8)] = spi_so;
        kind_seen = rf_kind;
      end
      spi_sck = 1'b1;
      if (race && i == 8 + nbits - 1) spi_cs_n = 1'b1;
      repeat (HP) @(negedge clk);
      spi_sck = 1'b0;
    end
    for (int e = 0; e < extra; e++) begin
      spi_si = 1'b1;
      repeat (HP) @(negedge clk); spi_sck = 1'b1;
      repeat (HP) @(negedge clk); spi_sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1; spi_sck = 1'b0;
    repeat (3*HP) @(negedge clk);
  endtask

  logic [255:0] dout;
  int w0, r0;

  task automatic t_reset();
    chk(spi_so_oe == 1'b0 && spi_so == 1'b0, "R11", "so idle after reset", {spi_so_oe, spi_so}, 0);
    chk(rf_wr == 1'b0 && rf_rd == 1'b0, "R11", "strobes after reset", {rf_wr, rf_rd}, 0);
    chk(rf_kind == 3'b000, "R11", "kind after reset", rf_kind, 0);
  endtask

  task automatic t_ctrl();
    w0 = wr_cnt;
    xfer({1'b0, 5'd3, 2'b11}, 8, 256'hA5, dout, -1, 0, 1'b0);
    chk(wr_cnt == w0 + 1, "R3", "ctrl write strobes", wr_cnt - w0, 1);
    chk(ctrl_m[3] == 8'hA5, "R1", "ctrl write with ignored low bits", ctrl_m[3], 8'hA5);
    chk(kind_seen == 3'b001, "R2", "ctrl kind", kind_seen, 3'b001);
    r0 = rd_cnt;
    xfer({1'b1, 5'd3, 2'b00}, 8, '0, dout, -1, 0, 1'b0);
    chk(dout[7:0] == 8'hA5, "R5", "ctrl readback", dout[7:0], 8'hA5);
    chk(rd_cnt == r0 + 1, "R5", "ctrl read strobes", rd_cnt - r0, 1);
    chk(!oe_op_seen, "R7", "so_oe during instruction", oe_op_seen, 0);
    xfer({1'b1, 5'd6, 2'b10}, 8, '0, dout, -1, 0, 1'b0);
    chk(dout[7:0] == 8'h16, "R5", "ctrl reset-value read", dout[7:0], 8'h16);
  endtask

  task automatic t_label();
    w0 = wr_cnt;
    xfer({1'b0, 5'd9, 2'b00}, 32, 256'hDEADBEEF, dout, -1, 0, 1'b0);
    chk(wr_cnt == w0 + 1, "R3", "label write strobes", wr_cnt - w0, 1);
    chk(lab_m[1] == 32'hDEADBEEF, "R3", "label word stored", lab_m[1], 32'hDEADBEEF);
    chk(kind_seen == 3'b010, "R2", "label kind", kind_seen, 3'b010);
    xfer({1'b1, 5'd9, 2'b01}, 32, '0, dout, -1, 0, 1'b0);
    chk(dout[31:0] == 32'hDEADBEEF, "R5", "label readback", dout[31:0], 32'hDEADBEEF);
  endtask

  task automatic t_match();
    logic [255:0] pat;
    for (int k = 0; k < 32; k++) pat[255-8*k -: 8] = 8'(k*37 + 11);
    w0 = wr_cnt;
    xfer({1'b0, 5'd13, 2'b00}, 256, pat, dout, -1, 0, 1'b0);
    chk(wr_cnt == w0 + 32, "R4", "match write strobes", wr_cnt - w0, 32);
    chk(order_err == 0, "R4", "match byte order", order_err, 0);
    chk(mat_m[1][0] == 8'd11 && mat_m[1][31] == 8'(31*37 + 11), "R4", "match bytes stored",
        {mat_m[1][0], mat_m[1][31]}, {8'd11, 8'(31*37 + 11)});
    chk(kind_seen == 3'b100, "R2", "match kind", kind_seen, 3'b100);
    r0 = rd_cnt;
    xfer({1'b1, 5'd13, 2'b00}, 256, '0, dout, -1, 0, 1'b0);
    chk(dout == pat, "R6", "match readback", dout, pat);
    chk(rd_cnt == r0 + 32, "R6", "match read strobes", rd_cnt - r0, 32);
  endtask

  task automatic t_abort();
    w0 = wr_cnt;
    xfer({1'b0, 5'd5, 2'b00}, 8, 256'h3C, dout, 13, 0, 1'b0);
    xfer({1'b0, 5'd10, 2'b00}, 32, 256'h12345678, dout, 28, 0, 1'b0);
    chk(wr_cnt == w0, "R8", "aborted writes strobes", wr_cnt - w0, 0);
    xfer({1'b1, 5'd5, 2'b00}, 8, '0, dout, -1, 0, 1'b0);
    chk(dout[7:0] == 8'h15, "R8", "ctrl unchanged after abort", dout[7:0], 8'h15);
    xfer({1'b1, 5'd10, 2'b00}, 32, '0, dout, -1, 0, 1'b0);
    chk(dout[31:0] == 32'h0, "R8", "label unchanged after abort", dout[31:0], 0);
  endtask

  task automatic t_race();
    w0 = wr_cnt;
    xfer({1'b0, 5'd2, 2'b00}, 8, 256'h77, dout, -1, 0, 1'b1);
    chk(wr_cnt == w0, "R8", "no commit when cs rises with last edge", wr_cnt - w0, 0);
    xfer({1'b1, 5'd2, 2'b00}, 8, '0, dout, -1, 0, 1'b0);
    chk(dout[7:0] == 8'h12, "R8", "ctrl after race", dout[7:0], 8'h12);
    xfer({1'b0, 5'd2, 2'b00}, 8, 256'h77, dout, -1, 0, 1'b0);
    chk(ctrl_m[2] == 8'h77, "R8", "commit with normal release", ctrl_m[2], 8'h77);
  endtask

  task automatic t_unknown();
    w0 = wr_cnt; r0 = rd_cnt;
    xfer({1'b0, 5'd20, 2'b00}, 8, 256'hFF, dout, -1, 0, 1'b0);
    chk(wr_cnt == w0, "R9", "unknown write dropped", wr_cnt - w0, 0);
    chk(kind_seen == 3'b000, "R2", "unknown kind", kind_seen, 0);
    xfer({1'b1, 5'd31, 2'b00}, 8, '0, dout, -1, 0, 1'b0);
    chk(dout[7:0] == 8'h00 && rd_cnt == r0, "R9", "unknown read zero, no strobe",
        {dout[7:0], 8'(rd_cnt - r0)}, 0);
  endtask

  task automatic t_extra();
    w0 = wr_cnt;
    xfer({1'b0, 5'd1, 2'b00}, 8, 256'h5A, dout, -1, 6, 1'b0);
    chk(wr_cnt == w0 + 1, "R10", "extra clocks after write", wr_cnt - w0, 1);
    chk(ctrl_m[1] == 8'h5A, "R10", "ctrl after extra clocks", ctrl_m[1], 8'h5A);
    r0 = rd_cnt;
    xfer({1'b1, 5'd1, 2'b00}, 8, '0, dout, -1, 5, 1'b0);
    chk(rd_cnt == r0 + 1 && dout[7:0] == 8'h5A, "R10", "extra clocks after read",
        {8'(rd_cnt - r0), dout[7:0]}, {8'd1, 8'h5A});
    chk(spi_so_oe == 1'b0, "R7", "so_oe after cs high", spi_so_oe, 0);
  endtask

  initial begin
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_si = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fork
      begin
        t_reset(); t_ctrl(); t_label(); t_match(); t_abort(); t_race(); t_unknown(); t_extra();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule